// File: doc/BRIEF.md
# Stack and Interrupt Return Sequencer

This block carries out the stack-related work of a 16-bit processor as multi-cycle sequences. There are six of them: pushing a word, popping a word, calling a subroutine, returning from one, returning from an interrupt, and entering an interrupt. The block owns the stack pointer, the program counter and the status register. It reaches stack memory through a single-port word interface. The read data arrives one cycle after the read strobe.

The surrounding core starts a sequence with a one-cycle `start` pulse and an operation code. It supplies the operand, which is the pushed word or the call target, and the interrupt vector address. It then waits for the one-cycle `done` pulse. Every sequence has a fixed length, whatever the data. Every stack access uses the current stack pointer as its address. The stack pointer therefore moves only in steps of two and stays even.

Top module: `stack_seq`

## Requirements
- R1: Push code 0 lowers SP by 2 in its first cycle, writes the operand at the new SP in its second cycle, and takes 2 cycles.
- R2: Pop code 1 reads the word at SP, presents it on `popData`, then raises SP by 2; it takes 3 cycles, and successive pops return pushed words in reverse order.
- R3: Call code 2 lowers SP by 2, writes the current PC at the new SP, then loads the operand into PC; it takes 3 cycles.
- R4: Return code 3 loads PC from the word at SP and raises SP by 2; it takes 3 cycles.
- R5: Interrupt return code 4 first loads the whole SR from the word at SP (lower address), raising SP by 2. It then loads PC from the next word, raising SP by 2 again. It takes 5 cycles and makes 2 reads.
- R6: Interrupt entry code 5 pushes PC and then SR, so SR sits at the lower address. It then clears SR bit `GIE_BIT` (default bit 3) and loads PC from `vector`. It takes 6 cycles and makes 2 writes.
- R7: SP bit 0 is always 0, SP changes only by plus or minus 2, and a read and a write are never strobed in the same cycle.
- R8: `done` is high for exactly one cycle, in the last cycle of a sequence. `busy` is high from the first cycle through the last. No memory strobe is raised while idle.
- R9: A `start` while `busy` is ignored, and codes 6 and 7 start nothing, leaving SP, PC and SR unchanged.
- R10: After reset, SP equals `SP_RESET` with bit 0 cleared, PC equals `PC_RESET` and SR is 0. The block is idle with no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| opCode | input | 3 | Sequence select, 0 to 5 |
| operand | input | DATA_W | Word to push or call target |
| vector | input | DATA_W | Interrupt entry address |
| memRdData | input | DATA_W | Read data, valid the cycle after `memRdEn` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last cycle of a sequence |
| sp | output | DATA_W | Stack pointer |
| pc | output | DATA_W | Program counter |
| sr | output | DATA_W | Status register |
| popData | output | DATA_W | Word taken by the last pop |
| memAddr | output | DATA_W | Word address (always SP) |
| memWrData | output | DATA_W | Write data |
| memRdEn | output | 1 | Read strobe |
| memWrEn | output | 1 | Write strobe |

## Verification
The bench builds the block with a 16-bit word, `SP_RESET` of 0x0080 and `GIE_BIT` of 3. All stack traffic then falls in a 64-word window, which a plain array can model completely. This lets the bench fill the whole window from empty to address zero and drain it again. It also lets the bench stage every interrupt return and interrupt entry through real pushes, so the order in which SR and PC are stored and restored can be observed in memory.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_IRQ  = 3'd5
  } seqOp_e;

  typedef enum logic [1:0] {
    WR_OPERAND = 2'd0,
    WR_PC      = 2'd1,
    WR_SR      = 2'd2
  } wrSrc_e;

  typedef enum logic [1:0] {
    PC_HOLD    = 2'd0,
    PC_MEM     = 2'd1,
    PC_OPERAND = 2'd2,
    PC_VECTOR  = 2'd3
  } pcSrc_e;

  typedef struct packed {
    logic   latchIn;
    logic   spDec;
    logic   spInc;
    logic   memRd;
    logic   memWr;
    wrSrc_e wrSrc;
    pcSrc_e pcSrc;
    logic   srFromMem;
    logic   clrGie;
    logic   popCap;
    logic   done;
  } seqStrobe_t;

  function automatic logic [STEP_W-1:0] seqLength(seqOp_e code);
    case (code)
      OP_PUSH: return STEP_W'(2);
      OP_POP:  return STEP_W'(3);
      OP_CALL: return STEP_W'(3);
      OP_RET:  return STEP_W'(3);
      OP_RETI: return STEP_W'(5);
      default: return STEP_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opCode,
  output logic       busy,
  output seqStrobe_t strobe
);

  seqOp_e              opReg;
  logic [STEP_W-1:0]   stepCnt;
  logic [STEP_W-1:0]   lastStep;
  logic                accept;

  assign busy     = (stepCnt != '0);
  assign lastStep = seqLength(opReg);
  assign accept   = start && !busy && (opCode <= 3'd5);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_PUSH;
      stepCnt <= '0;
    end else if (accept) begin
      opReg   <= seqOp_e'(opCode);
      stepCnt <= STEP_W'(1);
    end else if (busy) begin
      stepCnt <= (stepCnt == lastStep) ? '0 : stepCnt + STEP_W'(1);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.latchIn = accept;
    strobe.done    = busy && (stepCnt == lastStep);
    if (busy) begin
      case (opReg)
        OP_PUSH: begin
          if (stepCnt == 3'd1) strobe.spDec = 1'b1;
          if (stepCnt == 3'd2) begin
            strobe.memWr = 1'b1;
            strobe.wrSrc = WR_OPERAND;
          end
        end
        OP_POP: begin
          if (stepCnt == 3'd1) strobe.memRd = 1'b1;
          if (stepCnt == 3'd2) begin
            strobe.popCap = 1'b1;
            strobe.spInc  = 1'b1;
          end
        end
        OP_CALL: begin
          if (stepCnt == 3'd1) strobe.spDec = 1'b1;
          if (stepCnt == 3'd2) begin
            strobe.memWr = 1'b1;
            strobe.wrSrc = WR_PC;
          end
          if (stepCnt == 3'd3) strobe.pcSrc = PC_OPERAND;
        end
        OP_RET: begin
          if (stepCnt == 3'd1) strobe.memRd = 1'b1;
          if (stepCnt == 3'd2) begin
            strobe.pcSrc = PC_MEM;
            strobe.spInc = 1'b1;
          end
        end
        OP_RETI: begin
          if (stepCnt == 3'd1 || stepCnt == 3'd3) strobe.memRd = 1'b1;
          if (stepCnt == 3'd2) begin
            strobe.srFromMem = 1'b1;
            strobe.spInc     = 1'b1;
          end
          if (stepCnt == 3'd4) begin
            strobe.pcSrc = PC_MEM;
            strobe.spInc = 1'b1;
          end
        end
        default: begin
          if (stepCnt == 3'd1 || stepCnt == 3'd3) strobe.spDec = 1'b1;
          if (stepCnt == 3'd2) begin
            strobe.memWr = 1'b1;
            strobe.wrSrc = WR_PC;
          end
          if (stepCnt == 3'd4) begin
            strobe.memWr = 1'b1;
            strobe.wrSrc = WR_SR;
          end
          if (stepCnt == 3'd5) strobe.clrGie = 1'b1;
          if (stepCnt == 3'd6) strobe.pcSrc  = PC_VECTOR;
        end
      endcase
    end
  end

endmodule

// File: rtl/stack_seq_dpath.sv
module stack_seq_dpath
  import stack_seq_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] SP_RESET = 16'h0400,
  parameter logic [DATA_W-1:0] PC_RESET = 16'h0000,
  parameter int                GIE_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] vector,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] sr,
  output logic [DATA_W-1:0] popData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic              memWrEn
);

  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);
  localparam logic [DATA_W-1:0] SP_INIT   = {SP_RESET[DATA_W-1:1], 1'b0};

  logic [DATA_W-1:0] operandReg;
  logic [DATA_W-1:0] vectorReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operandReg <= '0;
      vectorReg  <= '0;
    end else if (strobe.latchIn) begin
      operandReg <= operand;
      vectorReg  <= vector;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= SP_INIT;
    end else if (strobe.spDec) begin
      sp <= sp - WORD_STEP;
    end else if (strobe.spInc) begin
      sp <= sp + WORD_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= PC_RESET;
    end else begin
      case (strobe.pcSrc)
        PC_MEM:     pc <= memRdData;
        PC_OPERAND: pc <= operandReg;
        PC_VECTOR:  pc <= vectorReg;
        default:    pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr <= '0;
    end else if (strobe.srFromMem) begin
      sr <= memRdData;
    end else if (strobe.clrGie) begin
      sr[GIE_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popData <= '0;
    end else if (strobe.popCap) begin
      popData <= memRdData;
    end
  end

  always_comb begin
    case (strobe.wrSrc)
      WR_PC:   memWrData = pc;
      WR_SR:   memWrData = sr;
      default: memWrData = operandReg;
    endcase
  end

  assign memAddr = sp;
  assign memRdEn = strobe.memRd;
  assign memWrEn = strobe.memWr;

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] SP_RESET = 16'h0400,
  parameter logic [DATA_W-1:0] PC_RESET = 16'h0000,
  parameter int                GIE_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] vector,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] sr,
  output logic [DATA_W-1:0] popData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic              memWrEn
);

  seqStrobe_t strobe;

  stack_seq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opCode (opCode),
    .busy   (busy),
    .strobe (strobe)
  );

  stack_seq_dpath #(
    .DATA_W   (DATA_W),
    .SP_RESET (SP_RESET),
    .PC_RESET (PC_RESET),
    .GIE_BIT  (GIE_BIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operand   (operand),
    .vector    (vector),
    .memRdData (memRdData),
    .sp        (sp),
    .pc        (pc),
    .sr        (sr),
    .popData   (popData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn)
  );

  assign done = strobe.done;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [DATA_W-1:0] sp
);

  localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

  // R7
  sp_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    sp[0] == 1'b0);

  // R7
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sp != $past(sp)) |-> (sp == $past(sp) + TWO || sp == $past(sp) - TWO));

  // R7
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !memWrEn));

endmodule

bind stack_seq stack_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    opCode = '0;
  logic [DW-1:0] operand = '0;
  logic [DW-1:0] vector = '0;
  logic [DW-1:0] memRdData = '0;
  logic          busy, done, memRdEn, memWrEn;
  logic [DW-1:0] sp, pc, sr, popData, memAddr, memWrData;

  int nChecks = 0;
  int nErr = 0;

  logic [DW-1:0] mem    [0:63];
  logic [DW-1:0] expMem [0:63];
  logic [DW-1:0] expSp = 16'h0080;
  logic [DW-1:0] expPc = 16'h0000;
  logic [DW-1:0] expSr = 16'h0000;

  always #2 clk = ~clk;

  stack_seq #(
    .DATA_W   (DW),
    .SP_RESET (16'h0080),
    .PC_RESET (16'h0000),
    .GIE_BIT  (3)
  ) u_stack_seq (.*);

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr[6:1]] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr[6:1]];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] code, input logic [DW-1:0] opd,
                       input logic [DW-1:0] vec, input bit poke,
                       output int cyc, output int wr, output int rd);
    @(negedge clk);
    start = 1'b1; opCode = code; operand = opd; vector = vec;
    cyc = 0; wr = 0; rd = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (memWrEn) wr++;
      if (memRdEn) rd++;
      start = poke && (cyc == 1);
      if (poke && cyc == 1) begin
        opCode = 3'd0; operand = 16'hDEAD;
      end
      if (done || cyc >= 20) break;
    end
    start = 1'b0;
    @(negedge clk);
    chk("R8", "done after last cycle", {31'd0, done}, 32'd0);
    chk("R8", "busy after last cycle", {31'd0, busy}, 32'd0);
  endtask

  task automatic doPush(input logic [DW-1:0] v);
    int c, w, r;
    runOp(3'd0, v, '0, 1'b0, c, w, r);
    expSp = expSp - 16'd2;
    expMem[expSp[6:1]] = v;
    chk("R1", "push cycles", c, 2);
    chk("R1", "push writes", w, 1);
    chk("R1", "push sp", sp, expSp);
    chk("R1", "push stored word", mem[expSp[6:1]], v);
    chk("R7", "sp bit0", {31'd0, sp[0]}, 32'd0);
  endtask

  task automatic doPop();
    int c, w, r;
    logic [DW-1:0] e;
    runOp(3'd1, '0, '0, 1'b0, c, w, r);
    e = expMem[expSp[6:1]];
    expSp = expSp + 16'd2;
    chk("R2", "pop cycles", c, 3);
    chk("R2", "pop reads", r, 1);
    chk("R2", "pop data", popData, e);
    chk("R2", "pop sp", sp, expSp);
  endtask

  task automatic doCall(input logic [DW-1:0] t);
    int c, w, r;
    runOp(3'd2, t, '0, 1'b0, c, w, r);
    expSp = expSp - 16'd2;
    expMem[expSp[6:1]] = expPc;
    chk("R3", "call cycles", c, 3);
    chk("R3", "call writes", w, 1);
    chk("R3", "call return address", mem[expSp[6:1]], expPc);
    expPc = t;
    chk("R3", "call pc", pc, expPc);
    chk("R3", "call sp", sp, expSp);
  endtask

  task automatic doRet();
    int c, w, r;
    runOp(3'd3, '0, '0, 1'b0, c, w, r);
    expPc = expMem[expSp[6:1]];
    expSp = expSp + 16'd2;
    chk("R4", "ret cycles", c, 3);
    chk("R4", "ret pc", pc, expPc);
    chk("R4", "ret sp", sp, expSp);
  endtask

  task automatic doReti(input bit poke);
    int c, w, r;
    runOp(3'd4, '0, '0, poke, c, w, r);
    expSr = expMem[expSp[6:1]];
    expSp = expSp + 16'd2;
    expPc = expMem[expSp[6:1]];
    expSp = expSp + 16'd2;
    chk("R5", "reti cycles", c, 5);
    chk("R5", "reti reads", r, 2);
    chk("R5", "reti sr", sr, expSr);
    chk("R5", "reti pc", pc, expPc);
    chk(poke ? "R9" : "R5", "reti sp", sp, expSp);
    if (poke) chk("R9", "writes during busy start", w, 0);
  endtask

  task automatic doIrq(input logic [DW-1:0] vec);
    int c, w, r;
    runOp(3'd5, '0, vec, 1'b0, c, w, r);
    expSp = expSp - 16'd2;
    expMem[expSp[6:1]] = expPc;
    chk("R6", "irq saved pc", mem[expSp[6:1]], expPc);
    expSp = expSp - 16'd2;
    expMem[expSp[6:1]] = expSr;
    chk("R6", "irq saved sr", mem[expSp[6:1]], expSr);
    expSr[3] = 1'b0;
    expPc = vec;
    chk("R6", "irq cycles", c, 6);
    chk("R6", "irq writes", w, 2);
    chk("R6", "irq sr", sr, expSr);
    chk("R6", "irq pc", pc, expPc);
    chk("R6", "irq sp", sp, expSp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset sp", sp, 16'h0080);
    chk("R10", "reset pc", pc, 16'h0000);
    chk("R10", "reset sr", sr, 16'h0000);
    chk("R10", "reset busy", {31'd0, busy}, 32'd0);
    chk("R10", "reset done", {31'd0, done}, 32'd0);
    chk("R10", "reset strobes", {30'd0, memRdEn, memWrEn}, 32'd0);

    // R1 and R2: fill the whole window down to address 0, then drain
    for (int i = 0; i < 64; i++) doPush(16'(i * 16'h1357) ^ 16'hA5A5);
    chk("R7", "sp at window floor", sp, 16'h0000);
    for (int i = 0; i < 64; i++) doPop();
    chk("R2", "sp back at top", sp, 16'h0080);

    // R3 and R4: nested calls then unwinding
    for (int i = 0; i < 8; i++) doCall(16'h1000 + 16'(i * 16'h0222));
    for (int i = 0; i < 8; i++) doRet();
    chk("R4", "pc after unwind", pc, 16'h0000);

    // R5 and R9: staged interrupt frames, busy start poked on odd passes
    for (int i = 0; i < 8; i++) begin
      doPush(16'h4000 + 16'(i * 16'h0106));
      doPush(16'hFFFF >> i);
      doReti(i[0]);
    end

    // R6: enter and leave interrupts with the enable bit set
    for (int i = 0; i < 4; i++) begin
      doPush(16'h2200 + 16'(i * 4));
      doPush(16'h0F08 | 16'(i));
      doReti(1'b0);
      doIrq(16'hFFE0 + 16'(i * 2));
      doReti(1'b0);
      chk("R6", "enable bit restored", {31'd0, sr[3]}, 32'd1);
    end

    // R9: unused codes start nothing
    for (int code = 6; code < 8; code++) begin
      @(negedge clk);
      start = 1'b1; opCode = 3'(code); operand = 16'h5555;
      @(negedge clk);
      start = 1'b0;
      chk("R9", "unused code busy", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R9", "unused code sp", sp, expSp);
      chk("R9", "unused code pc", pc, expPc);
      chk("R9", "unused code sr", sr, expSr);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule